// File: doc/BRIEF.md
# Inter-Processor Mailbox Unit

This block is the doorbell store between the cores of a multi-core cluster. It holds one 32-bit mailbox for each pair of (core, slot), four slots per core and four cores by default. Any agent on the register interface can raise bits in a mailbox by writing to that mailbox's set address. It can drop bits by writing to its clear address. The mailbox's owner sees an interrupt request for as long as the mailbox holds any nonzero bit. Software normally uses one slot per core as an inter-processor interrupt. The sender sets a bit and the receiving core clears it once it has handled it.

Each core has an 8-bit routing register. It picks, per slot, whether a pending mailbox drives the normal request line, the fast request line, or neither. The fast enable wins over the normal enable, so a slot never raises both lines at once. The register interface has several write ports that act in the same cycle and one combinational read port. The write ports let the set/clear and routing collisions between agents be resolved inside the block.

Top module: `ipi_mailbox_unit`

## Requirements
- R1: A synchronous active-low reset clears every mailbox and every routing register. Every irq_req and fiq_req bit is 0 after reset.
- R2: A write to byte address 0x080 + 0x10*core + 4*slot ORs the write data into that mailbox on the next clock edge.
- R3: A write to byte address 0x0C0 + 0x10*core + 4*slot clears, on the next clock edge, every mailbox bit that is 1 in the write data. Bits that are 0 in the write data are left as they are.
- R4: A read of either the set address or the clear address of a mailbox returns that mailbox's current contents, with no wait state.
- R5: When a set and a clear reach the same mailbox bit in the same cycle from different ports, the bit ends cleared.
- R6: The routing register of a core lives at byte address 0x050 + 4*core. Bits 0..3 are the normal enables of slots 0..3 and bits 4..7 are the fast enables. Only bits 7:0 are stored, and they read back with zeros above.
- R7: irq_req[4*core+slot] is 1 exactly when that mailbox is nonzero, its normal enable is 1 and its fast enable is 0.
- R8: fiq_req[4*core+slot] is 1 exactly when that mailbox is nonzero and its fast enable is 1, whatever the normal enable holds.
- R9: A write to a misaligned or unmapped address changes no mailbox and no routing register. A read of such an address returns 0.
- R10: Sets from several ports to one mailbox in one cycle all take effect. Writes from different ports to different mailboxes in one cycle all take effect.
- R11: When two ports write the same routing register in one cycle, the higher-numbered port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NUM_WPORTS | Write strobe per write port |
| wr_addr | input | NUM_WPORTS*ADDR_W | Byte address per write port, port p at bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WPORTS*DATA_W | Write data per write port, port p at bits [p*DATA_W +: DATA_W] |
| rd_addr | input | ADDR_W | Byte address of the read port |
| rd_data | output | DATA_W | Combinational read data |
| irq_req | output | NUM_CORES*SLOTS_PER_CORE | Normal request per mailbox, index 4*core+slot |
| fiq_req | output | NUM_CORES*SLOTS_PER_CORE | Fast request per mailbox, index 4*core+slot |

## Verification
The bench builds the block with four cores, four slots per core, 32-bit mailboxes and two write ports. Two write ports make same-cycle collisions possible: a set against a clear on one mailbox, two sets merging, and two routing writes racing. With the full default map, the bench can reach every set, clear and routing address and the unmapped gaps between them. After each scenario, the bench compares all sixteen mailboxes, the four routing registers and both request vectors against a model built from the address map.

// File: rtl/mbx_pkg.sv
// Package: shared address map constants for the mailbox unit.
// Assumes the set bank and clear bank each span at most 0x40 bytes
// (NUM_CORES*SLOTS_PER_CORE*4 <= 64) so the banks do not overlap.
package mbx_pkg;
    localparam int SET_BASE   = 'h080;
    localparam int CLR_BASE   = 'h0C0;
    localparam int ROUTE_BASE = 'h050;
    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/mbx_addr_decode.sv
// Module: mbx_addr_decode
// Turns one byte address into one-hot hit vectors for the set bank,
// the clear bank and the routing registers. Misaligned or unmapped
// addresses give all-zero vectors. Purely combinational.
module mbx_addr_decode #(
    parameter int NUM_CORES      = 4,
    parameter int SLOTS_PER_CORE = 4,
    parameter int ADDR_W         = 8,
    localparam int NUM_BOXES     = NUM_CORES * SLOTS_PER_CORE
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BOXES-1:0] set_hit,
    output logic [NUM_BOXES-1:0] clr_hit,
    output logic [NUM_CORES-1:0] route_hit
);
    import mbx_pkg::*;

    // Compare the address with every mapped word.
    always_comb begin
        int a;
        a = int'(addr);
        set_hit   = '0;
        clr_hit   = '0;
        route_hit = '0;
        for (int b = 0; b < NUM_BOXES; b++) begin
            set_hit[b] = (a == SET_BASE + WORD_BYTES * b);
            clr_hit[b] = (a == CLR_BASE + WORD_BYTES * b);
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            route_hit[c] = (a == ROUTE_BASE + WORD_BYTES * c);
        end
    end
endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One mailbox register. It applies the merged set bits and the merged
// clear bits of a cycle, and clear takes precedence. Assumes the
// inputs are already merged across write ports.
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] q
);
    // Mailbox state update: OR in the sets, then mask out the clears.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_bits) & ~clr_bits;
    end

    a_r1_slot_reset: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0 && clr_bits == '0) |=> ((q & $past(set_bits)) == $past(set_bits)));
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits != '0) |=> ((q & $past(clr_bits)) == '0));
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(q));
endmodule

// File: rtl/mbx_route.sv
// Module: mbx_route
// Routing register of one core and the steering of its mailbox
// requests. The low half holds the normal enables and the high half
// the fast enables; a fast enable masks the normal one.
module mbx_route #(
    parameter int SLOTS_PER_CORE = 4,
    localparam int ROUTE_W       = 2 * SLOTS_PER_CORE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      route_we,
    input  logic [ROUTE_W-1:0]        route_wd,
    input  logic [SLOTS_PER_CORE-1:0] pending,
    output logic [ROUTE_W-1:0]        route_q,
    output logic [SLOTS_PER_CORE-1:0] irq,
    output logic [SLOTS_PER_CORE-1:0] fiq
);
    logic [SLOTS_PER_CORE-1:0] irq_en;
    logic [SLOTS_PER_CORE-1:0] fiq_en;

    // Routing register load.
    always_ff @(posedge clk) begin
        if (!rst_n)        route_q <= '0;
        else if (route_we) route_q <= route_wd;
    end

    // Split enables and steer each pending slot to one line.
    always_comb begin
        irq_en = route_q[SLOTS_PER_CORE-1:0];
        fiq_en = route_q[ROUTE_W-1:SLOTS_PER_CORE];
        fiq    = pending & fiq_en;
        irq    = pending & irq_en & ~fiq_en;
    end

    a_r6_route_load: assert property (@(posedge clk) disable iff (!rst_n)
        route_we |=> (route_q == $past(route_wd)));
    a_r6_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !route_we |=> $stable(route_q));
endmodule

// File: rtl/ipi_mailbox_unit.sv
// Module: ipi_mailbox_unit (top)
// Mailbox store for inter-processor signalling. It has several
// same-cycle write ports and one combinational read port. Per port it
// decodes the address, merges sets and clears per mailbox, resolves
// routing writes (highest port wins) and drives per-mailbox requests.
// Assumes NUM_CORES*SLOTS_PER_CORE*4 <= 64 and DATA_W > 2*SLOTS_PER_CORE.
module ipi_mailbox_unit #(
    parameter int NUM_CORES      = 4,
    parameter int SLOTS_PER_CORE = 4,
    parameter int DATA_W         = 32,
    parameter int ADDR_W         = 8,
    parameter int NUM_WPORTS     = 2,
    localparam int NUM_BOXES     = NUM_CORES * SLOTS_PER_CORE,
    localparam int ROUTE_W       = 2 * SLOTS_PER_CORE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WPORTS-1:0]        wr_en,
    input  logic [NUM_WPORTS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WPORTS*DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_BOXES-1:0]         irq_req,
    output logic [NUM_BOXES-1:0]         fiq_req
);
    logic [NUM_BOXES-1:0] w_set_hit   [NUM_WPORTS];
    logic [NUM_BOXES-1:0] w_clr_hit   [NUM_WPORTS];
    logic [NUM_CORES-1:0] w_route_hit [NUM_WPORTS];
    logic [NUM_BOXES-1:0] r_set_hit;
    logic [NUM_BOXES-1:0] r_clr_hit;
    logic [NUM_CORES-1:0] r_route_hit;

    logic [DATA_W-1:0]    set_bits [NUM_BOXES];
    logic [DATA_W-1:0]    clr_bits [NUM_BOXES];
    logic [DATA_W-1:0]    box_q    [NUM_BOXES];
    logic [NUM_BOXES-1:0] pending;

    logic [NUM_CORES-1:0] route_we;
    logic [ROUTE_W-1:0]   route_wd [NUM_CORES];
    logic [ROUTE_W-1:0]   route_q  [NUM_CORES];

    // One address decoder per write port.
    for (genvar p = 0; p < NUM_WPORTS; p++) begin : g_wdec
        mbx_addr_decode #(
            .NUM_CORES(NUM_CORES), .SLOTS_PER_CORE(SLOTS_PER_CORE), .ADDR_W(ADDR_W)
        ) u_wdec (
            .addr     (wr_addr[p*ADDR_W +: ADDR_W]),
            .set_hit  (w_set_hit[p]),
            .clr_hit  (w_clr_hit[p]),
            .route_hit(w_route_hit[p])
        );

        a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[p] |-> $onehot0({w_set_hit[p], w_clr_hit[p], w_route_hit[p]}));
    end

    // Decoder for the read port.
    mbx_addr_decode #(
        .NUM_CORES(NUM_CORES), .SLOTS_PER_CORE(SLOTS_PER_CORE), .ADDR_W(ADDR_W)
    ) u_rdec (
        .addr     (rd_addr),
        .set_hit  (r_set_hit),
        .clr_hit  (r_clr_hit),
        .route_hit(r_route_hit)
    );

    // Merge set and clear data from all ports, per mailbox.
    always_comb begin
        for (int b = 0; b < NUM_BOXES; b++) begin
            set_bits[b] = '0;
            clr_bits[b] = '0;
            for (int p = 0; p < NUM_WPORTS; p++) begin
                if (wr_en[p] && w_set_hit[p][b]) set_bits[b] |= wr_data[p*DATA_W +: DATA_W];
                if (wr_en[p] && w_clr_hit[p][b]) clr_bits[b] |= wr_data[p*DATA_W +: DATA_W];
            end
        end
    end

    // Resolve routing writes; later (higher) ports override earlier ones.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            route_we[c] = 1'b0;
            route_wd[c] = '0;
            for (int p = 0; p < NUM_WPORTS; p++) begin
                if (wr_en[p] && w_route_hit[p][c]) begin
                    route_we[c] = 1'b1;
                    route_wd[c] = wr_data[p*DATA_W +: ROUTE_W];
                end
            end
        end
    end

    // Mailbox registers.
    for (genvar b = 0; b < NUM_BOXES; b++) begin : g_slot
        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_bits[b]),
            .clr_bits(clr_bits[b]),
            .q       (box_q[b])
        );
        assign pending[b] = |box_q[b];

        a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[b] |-> (box_q[b] != '0));
        a_r8_fiq_excludes_irq: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_req[b] |-> !irq_req[b]);
    end

    // Per-core routing and request steering.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        mbx_route #(.SLOTS_PER_CORE(SLOTS_PER_CORE)) u_route (
            .clk     (clk),
            .rst_n   (rst_n),
            .route_we(route_we[c]),
            .route_wd(route_wd[c]),
            .pending (pending[c*SLOTS_PER_CORE +: SLOTS_PER_CORE]),
            .route_q (route_q[c]),
            .irq     (irq_req[c*SLOTS_PER_CORE +: SLOTS_PER_CORE]),
            .fiq     (fiq_req[c*SLOTS_PER_CORE +: SLOTS_PER_CORE])
        );
    end

    // Read mux: either bank returns the mailbox, routing reads zero-extended.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BOXES; b++) begin
            if (r_set_hit[b] || r_clr_hit[b]) rd_data |= box_q[b];
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (r_route_hit[c]) rd_data |= {{(DATA_W-ROUTE_W){1'b0}}, route_q[c]};
        end
    end
endmodule

// File: tb/test_ipi_mailbox_unit.sv
// Directed bench for ipi_mailbox_unit. It keeps an independent model of
// the mailboxes and routing registers and compares every visible value.
module test_ipi_mailbox_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NS = 4;
    localparam int NB = NC * NS;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NP = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   wr_en = '0;
    logic [NP*AW-1:0] wr_addr = '0;
    logic [NP*DW-1:0] wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NB-1:0]   irq_req;
    logic [NB-1:0]   fiq_req;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] mb [NB];
    logic [7:0]    rt [NC];

    ipi_mailbox_unit #(
        .NUM_CORES(NC), .SLOTS_PER_CORE(NS), .DATA_W(DW), .ADDR_W(AW), .NUM_WPORTS(NP)
    ) i_ipi_mailbox_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] set_a(int b);  return 8'(8'h80 + 4*b); endfunction
    function automatic logic [7:0] clr_a(int b);  return 8'(8'hC0 + 4*b); endfunction
    function automatic logic [7:0] rte_a(int c);  return 8'(8'h50 + 4*c); endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Drive up to two writes in one cycle; returns at the following negedge.
    task automatic wr2(logic e0, logic [7:0] a0, logic [DW-1:0] d0,
                       logic e1, logic [7:0] a1, logic [DW-1:0] d1);
        @(negedge clk);
        wr_en   = {e1, e0};
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [DW-1:0] d);
        wr2(1'b1, a, d, 1'b0, 8'h00, '0);
    endtask

    // Compare every register and both request vectors against the model.
    task automatic check_all(string req);
        logic [DW-1:0] v;
        logic [NB-1:0] ei, ef;
        for (int b = 0; b < NB; b++) begin
            rd(set_a(b), v); chk(req, v, mb[b]);
            rd(clr_a(b), v); chk({req, "/R4"}, v, mb[b]);
            ef[b] = (mb[b] != 0) && rt[b/NS][NS + b%NS];
            ei[b] = (mb[b] != 0) && rt[b/NS][b%NS] && !rt[b/NS][NS + b%NS];
        end
        for (int c = 0; c < NC; c++) begin
            rd(rte_a(c), v); chk({req, "/R6"}, v, {24'h0, rt[c]});
        end
        chk({req, "/R7"}, DW'(irq_req), DW'(ei));
        chk({req, "/R8"}, DW'(fiq_req), DW'(ef));
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        for (int b = 0; b < NB; b++) mb[b] = '0;
        for (int c = 0; c < NC; c++) rt[c] = '0;
        wr2(1'b1, set_a(0), 32'hFFFF_FFFF, 1'b1, 8'h50, 32'hFF);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(set_a(0), v); chk("R1 mailbox after reset", v, '0);
        check_all("R1");
    endtask

    task automatic t_set;
        wr(set_a(0), 32'h0000_00F0);
        wr(set_a(0), 32'h0000_000F); mb[0] = 32'hFF;
        wr(8'hAC, 32'hA5A5_0000);    mb[11] = 32'hA5A5_0000;
        check_all("R2");
    endtask

    task automatic t_clear;
        wr(8'hC0, 32'h0000_000F);    mb[0] = 32'hF0;
        wr(8'hEC, 32'hFFFF_0000);    mb[11] = '0;
        check_all("R3");
    endtask

    task automatic t_clear_wins;
        wr2(1'b1, set_a(5), 32'hFF, 1'b1, clr_a(5), 32'h0F); mb[5] = 32'hF0;
        check_all("R5");
    endtask

    task automatic t_multi;
        wr2(1'b1, 8'h84, 32'h1, 1'b1, 8'h84, 32'h2);   mb[1] = 32'h3;
        wr2(1'b1, 8'hB0, 32'h100, 1'b1, 8'hC4, 32'h1); mb[12] = 32'h100; mb[1] = 32'h2;
        check_all("R10");
    endtask

    task automatic t_routing;
        wr(8'h50, 32'h0F);           rt[0] = 8'h0F;
        check_all("R7");
        wr(8'h50, 32'hFFFF_FF0F);    rt[0] = 8'h0F;
        check_all("R6");
    endtask

    task automatic t_fast;
        wr(8'h50, 32'h1F);           rt[0] = 8'h1F;
        wr(8'h5C, 32'h10);           rt[3] = 8'h10;
        wr(8'h54, 32'h22);           rt[1] = 8'h22;
        check_all("R8");
        chk("R8 fast only", DW'(fiq_req[12]), 1);
        chk("R8 no normal", DW'(irq_req[0]), 0);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        wr(8'h82, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'hC1, 32'hFFFF_FFFF);
        rd(8'h60, v); chk("R9 unmapped read", v, '0);
        rd(8'h82, v); chk("R9 misaligned read", v, '0);
        check_all("R9");
    endtask

    task automatic t_route_race;
        wr2(1'b1, 8'h58, 32'h03, 1'b1, 8'h58, 32'h30); rt[2] = 8'h30;
        check_all("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clear();
        t_clear_wins();
        t_multi();
        t_routing();
        t_fast();
        t_unmapped();
        t_route_race();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule